// File: doc/BRIEF.md
# Next Program Counter and Link Unit

This block works out where an integer core fetches next and what return address a jump leaves behind. It is purely combinational. Each cycle it takes the current program counter, the two register operands, an immediate that is already sign-extended, the destination register index, a transfer kind and the branch condition code. From these it produces the following PC, the link value, a link write enable, a taken flag and an instruction-misaligned flag.

The unit evaluates six branch conditions: equality, inequality, signed ordering and unsigned ordering. Three target formulas are computed side by side: PC-relative for branches, PC-relative in 2-byte units for jump-and-link, and register-indirect for jump-and-link-register. A final select picks either the sequential address or the target.

Parameters set the data width, the instruction step, the alignment that is checked, the jump immediate scaling and the comparator style. The comparator is either one shared extended subtractor or separate relational operators.

Top module: `nxpc_unit`

## Requirements
- R1: Transfer kind code 2'b00 is sequential: next_pc equals pc_i plus 4, taken is 0, link_val is 0 and link_we is 0.
- R2: For kind 2'b01 (conditional branch), next_pc is pc_i plus imm_i when the condition holds and pc_i plus 4 when it does not.
- R3: Condition code 3'b000 holds when rs1_val equals rs2_val. Condition code 3'b001 holds when they differ.
- R4: Condition code 3'b100 holds when rs1_val < rs2_val as signed values, and 3'b101 when rs1_val >= rs2_val as signed values. Codes 3'b110 and 3'b111 apply the same two tests to unsigned values. Codes 3'b010 and 3'b011 never hold.
- R5: Kind 2'b10 (jump-and-link) sets next_pc to pc_i plus imm_i shifted left by one, and link_val to pc_i plus 4.
- R6: Kind 2'b11 (register jump-and-link) sets next_pc to rs1_val plus imm_i with bit 0 forced to 0, and link_val to pc_i plus 4.
- R7: taken is 1 for both jump kinds and for a branch whose condition holds, and 0 otherwise. link_val is 0 for any kind that is not a jump.
- R8: link_we is 1 only for a jump kind whose rd_idx is nonzero. A link aimed at register 0 is never written.
- R9: misaligned is 1 exactly when taken is 1 and bits [1:0] of next_pc are not both 0. A branch that is not taken never flags, even when its target would be misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| rd_idx | input | 5 | Destination register index |
| kind_i | input | 2 | Transfer kind: 00 sequential, 01 branch, 10 jump-and-link, 11 register jump-and-link |
| cond_i | input | 3 | Branch condition code |
| next_pc | output | 32 | Address to fetch next |
| link_val | output | 32 | Return address for jumps, 0 otherwise |
| link_we | output | 1 | Link write enable |
| taken | output | 1 | Control transfer taken |
| misaligned | output | 1 | Taken target not 4-byte aligned |

## Verification
The sweep aims at the corners of the comparator: operands that differ only in the sign bit, the most positive value against the most negative, and equal values under every code. A design that mixed up signed and unsigned ordering would take the wrong path on exactly those pairs, and an unused code that leaked through would branch when it must not. Register-indirect targets with an odd sum expose a missing bit-0 clear. Jump offsets expose a missing or doubled shift. Destination index 0 exposes a link write that should be suppressed. Branches with misaligned targets are driven both taken and not taken, so the check catches a flag that ignores the taken condition.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

   typedef enum logic [1:0] {
      XFER_SEQ    = 2'b00,
      XFER_BRANCH = 2'b01,
      XFER_JAL    = 2'b10,
      XFER_JALR   = 2'b11
   } xfer_e;

   localparam logic [2:0] CC_EQ  = 3'b000;
   localparam logic [2:0] CC_NE  = 3'b001;
   localparam logic [2:0] CC_LT  = 3'b100;
   localparam logic [2:0] CC_GE  = 3'b101;
   localparam logic [2:0] CC_LTU = 3'b110;
   localparam logic [2:0] CC_GEU = 3'b111;

   function automatic logic is_jump(input xfer_e k);
      return (k == XFER_JAL) || (k == XFER_JALR);
   endfunction

endpackage

// File: rtl/nxpc_cond.sv
module nxpc_cond
   import nxpc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [2:0]      cc_i,
   output logic            hit_o
);
   localparam int EXT = XLEN + 1;

   logic eq;
   logic lt_s;
   logic lt_u;

   assign eq = (a_i == b_i);

   generate
      if (SHARED_SUB) begin : g_shared
         logic            use_sign;
         logic [EXT-1:0]  a_ext;
         logic [EXT-1:0]  b_ext;
         logic [EXT-1:0]  diff;
         logic            lt_any;
         assign use_sign = ~cc_i[1];
         assign a_ext    = {use_sign & a_i[XLEN-1], a_i};
         assign b_ext    = {use_sign & b_i[XLEN-1], b_i};
         assign diff     = a_ext - b_ext;
         assign lt_any   = diff[EXT-1];
         assign lt_s     = lt_any;
         assign lt_u     = lt_any;
      end else begin : g_direct
         assign lt_s = ($signed(a_i) < $signed(b_i));
         assign lt_u = (a_i < b_i);
      end
   endgenerate

   always_comb begin
      unique case (cc_i)
         CC_EQ:   hit_o = eq;
         CC_NE:   hit_o = ~eq;
         CC_LT:   hit_o = lt_s;
         CC_GE:   hit_o = ~lt_s;
         CC_LTU:  hit_o = lt_u;
         CC_GEU:  hit_o = ~lt_u;
         default: hit_o = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, cc_i})) begin
         AST_EQ_NE_OPPOSE: assert (!(cc_i == CC_EQ && hit_o && a_i != b_i))
            else $error("equal code hit on differing operands"); // R3
         AST_UNUSED_CODE: assert (!((cc_i == 3'b010 || cc_i == 3'b011) && hit_o))
            else $error("unused condition code hit"); // R4
      end
   end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
   import nxpc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int STEP_BYTES = 4,
   parameter int JAL_SHL    = 1
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] imm_i,
   output logic [XLEN-1:0] seq_o,
   output logic [XLEN-1:0] br_o,
   output logic [XLEN-1:0] jal_o,
   output logic [XLEN-1:0] jalr_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

   logic [XLEN-1:0] jal_off;
   logic [XLEN-1:0] ind_sum;

   assign seq_o   = pc_i + STEP;
   assign br_o    = pc_i + imm_i;
   assign jal_off = imm_i << JAL_SHL;
   assign jal_o   = pc_i + jal_off;
   assign ind_sum = rs1_i + imm_i;
   assign jalr_o  = {ind_sum[XLEN-1:1], 1'b0};

   always_comb begin
      if (!$isunknown({rs1_i, imm_i})) begin
         AST_JALR_EVEN: assert (jalr_o[0] == 1'b0)
            else $error("indirect target is odd"); // R6
         AST_JALR_UPPER: assert (jalr_o[XLEN-1:1] == ind_sum[XLEN-1:1])
            else $error("indirect target upper bits lost"); // R6
      end
   end

endmodule

// File: rtl/nxpc_align.sv
module nxpc_align #(
   parameter int XLEN        = 32,
   parameter int ALIGN_BYTES = 4
) (
   input  logic [XLEN-1:0] addr_i,
   input  logic            en_i,
   output logic            bad_o
);
   localparam int LOW = $clog2(ALIGN_BYTES);

   generate
      if (LOW == 0) begin : g_none
         assign bad_o = 1'b0;
      end else begin : g_check
         assign bad_o = en_i & (|addr_i[LOW-1:0]);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({addr_i, en_i})) begin
         AST_MISALIGN_NEEDS_TAKEN: assert (!(bad_o && !en_i))
            else $error("misaligned raised without a taken transfer"); // R9
      end
   end

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
   import nxpc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int RIDX_W      = 5,
   parameter int STEP_BYTES  = 4,
   parameter int ALIGN_BYTES = 4,
   parameter int JAL_SHL     = 1,
   parameter bit SHARED_SUB  = 1'b1
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   input  logic [XLEN-1:0]   imm_i,
   input  logic [RIDX_W-1:0] rd_idx,
   input  logic [1:0]        kind_i,
   input  logic [2:0]        cond_i,
   output logic [XLEN-1:0]   next_pc,
   output logic [XLEN-1:0]   link_val,
   output logic              link_we,
   output logic              taken,
   output logic              misaligned
);
   localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN must be at least 8");
      end
      if (RIDX_W < 1) begin : g_bad_ridx
         $error("RIDX_W must be positive");
      end
      if ((ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0 || ALIGN_BYTES < 1) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two");
      end
      if (STEP_BYTES < 1 || JAL_SHL < 0 || JAL_SHL > 3) begin : g_bad_step
         $error("STEP_BYTES or JAL_SHL out of range");
      end
   endgenerate

   xfer_e           kind;
   logic            cond_hit;
   logic            jump;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jal_tgt;
   logic [XLEN-1:0] jalr_tgt;
   logic [XLEN-1:0] tgt;

   assign kind = xfer_e'(kind_i);
   assign jump = is_jump(kind);

   nxpc_cond #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cond (
      .a_i   (rs1_val),
      .b_i   (rs2_val),
      .cc_i  (cond_i),
      .hit_o (cond_hit)
   );

   nxpc_target #(.XLEN(XLEN), .STEP_BYTES(STEP_BYTES), .JAL_SHL(JAL_SHL)) u_tgt (
      .pc_i   (pc_i),
      .rs1_i  (rs1_val),
      .imm_i  (imm_i),
      .seq_o  (seq_pc),
      .br_o   (br_tgt),
      .jal_o  (jal_tgt),
      .jalr_o (jalr_tgt)
   );

   always_comb begin
      unique case (kind)
         XFER_BRANCH: tgt = br_tgt;
         XFER_JAL:    tgt = jal_tgt;
         XFER_JALR:   tgt = jalr_tgt;
         default:     tgt = seq_pc;
      endcase
   end

   assign taken    = jump | ((kind == XFER_BRANCH) & cond_hit);
   assign next_pc  = taken ? tgt : seq_pc;
   assign link_val = jump ? seq_pc : '0;
   assign link_we  = jump & (|rd_idx);

   nxpc_align #(.XLEN(XLEN), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
      .addr_i (tgt),
      .en_i   (taken),
      .bad_o  (misaligned)
   );

   always_comb begin
      if (!$isunknown({pc_i, rs1_val, rs2_val, imm_i, rd_idx, kind_i, cond_i})) begin
         AST_SEQ_STEP: assert (!(kind_i == 2'b00 && (next_pc != pc_i + STEP || taken)))
            else $error("sequential transfer did not step"); // R1
         AST_BR_FALLTHRU: assert (!(kind_i == 2'b01 && !taken && next_pc != pc_i + STEP))
            else $error("untaken branch left the sequence"); // R2
         AST_JUMP_TAKEN: assert (!(kind_i[1] && !taken))
            else $error("jump not marked taken"); // R7
         AST_X0_LINK: assert (!(rd_idx == '0 && link_we))
            else $error("link written to register zero"); // R8
         AST_LINK_ZERO: assert (!(!kind_i[1] && link_val != '0))
            else $error("link value on non-jump"); // R7
      end
   end

endmodule

// File: tb/nxpc_unit_test.sv
module nxpc_unit_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] pc_i, rs1_val, rs2_val, imm_i;
   logic [4:0]  rd_idx;
   logic [1:0]  kind_i;
   logic [2:0]  cond_i;
   logic [31:0] next_pc, link_val;
   logic        link_we, taken, misaligned;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   nxpc_unit uut (
      .pc_i(pc_i), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_i(imm_i),
      .rd_idx(rd_idx), .kind_i(kind_i), .cond_i(cond_i),
      .next_pc(next_pc), .link_val(link_val), .link_we(link_we),
      .taken(taken), .misaligned(misaligned)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit cond_holds(input logic [2:0] cc, input logic [31:0] a,
                                     input logic [31:0] b);
      case (cc)
         3'b000: return a == b;
         3'b001: return a != b;
         3'b100: return $signed(a) < $signed(b);
         3'b101: return $signed(a) >= $signed(b);
         3'b110: return a < b;
         3'b111: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   task automatic run(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] imm, input logic [1:0] k, input logic [2:0] cc,
                      input logic [4:0] rd);
      logic [31:0] e_pc, e_link;
      bit e_tk, e_we, e_mis;
      string tag;
      @(negedge clk);
      pc_i = pc; rs1_val = a; rs2_val = b; imm_i = imm;
      kind_i = k; cond_i = cc; rd_idx = rd;
      #1;
      e_link = 32'h0;
      case (k)
         2'b00: begin e_tk = 0; e_pc = pc + 4; tag = "R1"; end
         2'b01: begin
            e_tk = cond_holds(cc, a, b);
            e_pc = e_tk ? pc + imm : pc + 4;
            tag = (cc[2] || cc[1]) ? "R4" : "R3";
         end
         2'b10: begin e_tk = 1; e_pc = pc + imm * 2; e_link = pc + 4; tag = "R5"; end
         default: begin
            e_tk = 1; e_pc = (a + imm) & 32'hFFFF_FFFE; e_link = pc + 4; tag = "R6";
         end
      endcase
      e_we  = k[1] && rd != 0;
      e_mis = e_tk && e_pc[1:0] != 2'b00;
      chk(tag, "taken R7", {31'b0, taken}, {31'b0, e_tk});
      chk(k == 2'b01 ? "R2" : tag, "next_pc", next_pc, e_pc);
      chk("R7", "link_val", link_val, e_link);
      chk("R8", "link_we", {31'b0, link_we}, {31'b0, e_we});
      chk("R9", "misaligned", {31'b0, misaligned}, {31'b0, e_mis});
   endtask

   logic [31:0] ops [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};

   initial begin
      pc_i = '0; rs1_val = '0; rs2_val = '0; imm_i = '0;
      rd_idx = '0; kind_i = '0; cond_i = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 idle state with all-zero inputs
      chk("R1", "idle next_pc", next_pc, 32'h4);
      chk("R1", "idle taken", {31'b0, taken}, 32'h0);
      // R1 sequential at several PCs
      run(32'h0000_1000, 32'h3, 32'h3, 32'h40, 2'b00, 3'b000, 5'd1);
      run(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h6, 2'b00, 3'b001, 5'd0);
      // R2 R3 R4 branch sweep over operand pairs and every code
      for (int cc = 0; cc < 8; cc++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               run(32'h0000_2000, ops[i], ops[j], (i + j) % 3 == 0 ? 32'hFFFF_FFF4 : 32'h10,
                   2'b01, 3'(cc), 5'(i + j));
      // R9 misaligned branch target, taken and not taken
      run(32'h0000_3000, 32'h7, 32'h7, 32'h6, 2'b01, 3'b000, 5'd0);
      run(32'h0000_3000, 32'h7, 32'h8, 32'h6, 2'b01, 3'b000, 5'd0);
      // R5 jump-and-link offsets, rd zero and nonzero
      run(32'h0000_4000, 32'h0, 32'h0, 32'h8,        2'b10, 3'b000, 5'd1);
      run(32'h0000_4000, 32'h0, 32'h0, 32'hFFFF_FFF8, 2'b10, 3'b000, 5'd0);
      run(32'h0000_4000, 32'h0, 32'h0, 32'h3,        2'b10, 3'b000, 5'd5);
      // R6 register jump-and-link, odd sums clear bit 0
      run(32'h0000_5000, 32'h0000_6001, 32'h0, 32'h0,  2'b11, 3'b000, 5'd0);
      run(32'h0000_5000, 32'h0000_6000, 32'h0, 32'h7,  2'b11, 3'b000, 5'd31);
      run(32'h0000_5000, 32'h0000_6004, 32'h0, 32'hFFFF_FFFC, 2'b11, 3'b000, 5'd1);
      run(32'h0000_5000, 32'hFFFF_FFFF, 32'h0, 32'h3,  2'b11, 3'b000, 5'd2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule